// File: doc/BRIEF.md
# Debug Command Sequencer

This block turns one host debug command into the byte traffic a two-wire debug transceiver has to carry. A command is a host verb code with up to two argument bytes. The sequencer maps the verb to a target opcode, a number of bytes to send and a number of reply bytes to collect. It then asks the transceiver for one byte operation at a time, first the writes and then the reads. When the last operation is done it presents a single reply beat. The beat carries a status code (normally the verb itself), a reply length and the collected bytes.

Two generic verbs carry raw traffic. The read verb sends every supplied argument and then collects exactly one byte. The write verb only sends. Two more verbs ask the transceiver to run its debug entry and exit sequences. Any other verb is answered with a not-acknowledged code and no payload, and no link operation is started for it. Only one command is in flight at a time.

Top module: `dcs_seq`

## Requirements
- R1: After reset, cmd_ready is 1, and rsp_valid and lnk_req are both 0.
- R2: Verb 0x00 (generic read) sends the first cmd_nargs argument bytes in lane order, lane 0 first, then performs exactly one read. The reply code is 0x00 and the length is 1.
- R3: Verb 0x01 (generic write) sends the first cmd_nargs argument bytes in lane order and performs no read. The reply code is 0x01 and the length is 0. With zero arguments no link operation occurs at all.
- R4: Verb 0x80 sends the single opcode 0x14, then reads one byte. The reply code is 0x80 and the length is 1.
- R5: Verb 0x81 sends opcode 0x1D and then argument lane 0, then reads one byte. Argument lane 1 is not sent.
- R6: Verbs 0x82, 0x84, 0x86, 0x87 and 0x89 each send one opcode and read one byte. The opcodes are 0x24, 0x34, 0x44, 0x4C and 0x5C respectively.
- R7: Verbs 0x83 and 0x8B send opcodes 0x28 and 0x68 respectively and read two bytes. Reply bytes appear on rsp_data in arrival order: the first byte is in bits 7:0 and the second in bits 15:8. Unfilled lanes read 0.
- R8: Every other verb, including 0x88, 0x8A and 0x90 to 0x98, gets reply code 0x7E, length 0 and data 0, and never raises lnk_req.
- R9: Verb 0x20 issues exactly one link operation with lnk_op 2 (debug entry). Verb 0x21 issues exactly one with lnk_op 3 (debug exit). Each replies with its verb and length 0.
- R10: cmd_ready is 0 from the cycle after a command is accepted until the cycle after the reply is taken. A reply that is not taken holds rsp_code, rsp_len and rsp_data stable.
- R11: A link request holds lnk_op and lnk_wdata stable until the cycle in which lnk_done is 1. Byte writes use lnk_op 0 and byte reads use lnk_op 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_verb | input | 8 | Host verb code |
| cmd_nargs | input | 2 | Number of valid argument bytes |
| cmd_args | input | 16 | Argument bytes, lane 0 in bits 7:0 |
| lnk_req | output | 1 | Link operation requested |
| lnk_op | output | 2 | 0 write byte, 1 read byte, 2 debug entry, 3 debug exit |
| lnk_wdata | output | 8 | Byte to write |
| lnk_done | input | 1 | Transceiver finished the current operation |
| lnk_rdata | input | 8 | Byte read, valid with lnk_done |
| rsp_valid | output | 1 | Reply beat present |
| rsp_ready | input | 1 | Host takes the reply |
| rsp_code | output | 8 | Verb echo or 0x7E |
| rsp_len | output | 2 | Number of reply bytes |
| rsp_data | output | 16 | Reply bytes in arrival order |

## Verification
A wrong decode entry shows up as a wrong link byte, a wrong byte count or a wrong reply code, within the burst of that same command. Sweeping all 256 verbs therefore exposes every table slot. A stuck or miscounted burst index repeats or skips a write, or puts a read byte in the wrong lane, and this is visible when the reply beat appears. A state machine that leaves its idle state wrongly drops cmd_ready or raises lnk_req. This is visible on the very next cycle, before any reply.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
   localparam logic [7:0] VERB_GEN_READ   = 8'h00;
   localparam logic [7:0] VERB_GEN_WRITE  = 8'h01;
   localparam logic [7:0] VERB_LINK_ENTER = 8'h20;
   localparam logic [7:0] VERB_LINK_EXIT  = 8'h21;
   localparam logic [7:0] CODE_NAK        = 8'h7E;

   typedef enum logic [1:0] {
      LOP_WRITE = 2'd0,
      LOP_READ  = 2'd1,
      LOP_ENTER = 2'd2,
      LOP_EXIT  = 2'd3
   } lop_e;

   typedef enum logic [1:0] {
      KIND_NAK,
      KIND_XFER,
      KIND_ENTER,
      KIND_EXIT
   } kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_RECV,
      ST_SYS,
      ST_RESP
   } st_e;
endpackage

// File: rtl/dcs_decode.sv
module dcs_decode
   import dcs_pkg::*;
#(
   parameter  int MAX_ARGS = 2,
   parameter  int MAX_RPL  = 2,
   localparam int NTX      = (MAX_ARGS > 2) ? MAX_ARGS : 2,
   localparam int AW       = $clog2(MAX_ARGS + 1),
   localparam int CW       = $clog2(NTX + 1),
   localparam int RW       = $clog2(MAX_RPL + 1)
) (
   input  logic [7:0]            verb,
   input  logic [AW-1:0]         nargs,
   input  logic [MAX_ARGS*8-1:0] args,
   output kind_e                 kind,
   output logic [CW-1:0]         n_tx,
   output logic [NTX*8-1:0]      tx_bytes,
   output logic [RW-1:0]         n_rx
);
   if (MAX_ARGS < 1) begin : g_bad_args
      $error("dcs_decode: MAX_ARGS must be at least 1");
   end
   if (MAX_RPL < 2) begin : g_bad_rpl
      $error("dcs_decode: MAX_RPL must be at least 2");
   end

   logic [AW-1:0] nclamp;
   assign nclamp = (nargs > AW'(MAX_ARGS)) ? AW'(MAX_ARGS) : nargs;

   always_comb begin
      kind     = KIND_NAK;
      n_tx     = '0;
      tx_bytes = '0;
      n_rx     = '0;
      case (verb)
         VERB_GEN_READ: begin
            kind                    = KIND_XFER;
            n_tx                    = CW'(nclamp);
            tx_bytes[MAX_ARGS*8-1:0] = args;
            n_rx                    = RW'(1);
         end
         VERB_GEN_WRITE: begin
            kind                    = KIND_XFER;
            n_tx                    = CW'(nclamp);
            tx_bytes[MAX_ARGS*8-1:0] = args;
         end
         VERB_LINK_ENTER: kind = KIND_ENTER;
         VERB_LINK_EXIT:  kind = KIND_EXIT;
         8'h80: begin
            kind = KIND_XFER; tx_bytes[7:0] = 8'h14; n_tx = CW'(1); n_rx = RW'(1);
         end
         8'h81: begin
            kind           = KIND_XFER;
            tx_bytes[7:0]  = 8'h1D;
            tx_bytes[15:8] = args[7:0];
            n_tx           = CW'(2);
            n_rx           = RW'(1);
         end
         8'h82: begin
            kind = KIND_XFER; tx_bytes[7:0] = 8'h24; n_tx = CW'(1); n_rx = RW'(1);
         end
         8'h84: begin
            kind = KIND_XFER; tx_bytes[7:0] = 8'h34; n_tx = CW'(1); n_rx = RW'(1);
         end
         8'h86: begin
            kind = KIND_XFER; tx_bytes[7:0] = 8'h44; n_tx = CW'(1); n_rx = RW'(1);
         end
         8'h87: begin
            kind = KIND_XFER; tx_bytes[7:0] = 8'h4C; n_tx = CW'(1); n_rx = RW'(1);
         end
         8'h89: begin
            kind = KIND_XFER; tx_bytes[7:0] = 8'h5C; n_tx = CW'(1); n_rx = RW'(1);
         end
         8'h83: begin
            kind = KIND_XFER; tx_bytes[7:0] = 8'h28; n_tx = CW'(1); n_rx = RW'(2);
         end
         8'h8B: begin
            kind = KIND_XFER; tx_bytes[7:0] = 8'h68; n_tx = CW'(1); n_rx = RW'(2);
         end
         default: kind = KIND_NAK;
      endcase
   end
endmodule

// File: rtl/dcs_rx_buf.sv
module dcs_rx_buf #(
   parameter  int MAX_RPL = 2,
   localparam int RW      = $clog2(MAX_RPL + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr_en,
   input  logic [7:0]           wr_byte,
   output logic [MAX_RPL*8-1:0] data,
   output logic [RW-1:0]        count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clr)   count <= '0;
      else if (wr_en) count <= count + RW'(1);
   end

   for (genvar i = 0; i < MAX_RPL; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           data[i*8 +: 8] <= '0;
         else if (clr)                         data[i*8 +: 8] <= '0;
         else if (wr_en && count == RW'(i))    data[i*8 +: 8] <= wr_byte;
      end
   end

   // R7: a reply byte never arrives beyond the buffer depth
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> count < RW'(MAX_RPL));
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
   import dcs_pkg::*;
#(
   parameter  int MAX_ARGS = 2,
   parameter  int MAX_RPL  = 2,
   localparam int NTX      = (MAX_ARGS > 2) ? MAX_ARGS : 2,
   localparam int AW       = $clog2(MAX_ARGS + 1),
   localparam int CW       = $clog2(NTX + 1),
   localparam int RW       = $clog2(MAX_RPL + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic [7:0]           cmd_verb,
   input  logic [AW-1:0]        cmd_nargs,
   input  logic [MAX_ARGS*8-1:0] cmd_args,
   output logic                 lnk_req,
   output logic [1:0]           lnk_op,
   output logic [7:0]           lnk_wdata,
   input  logic                 lnk_done,
   input  logic [7:0]           lnk_rdata,
   output logic                 rsp_valid,
   input  logic                 rsp_ready,
   output logic [7:0]           rsp_code,
   output logic [RW-1:0]        rsp_len,
   output logic [MAX_RPL*8-1:0] rsp_data
);
   kind_e            d_kind;
   logic [CW-1:0]    d_ntx;
   logic [NTX*8-1:0] d_tx;
   logic [RW-1:0]    d_nrx;

   dcs_decode #(.MAX_ARGS(MAX_ARGS), .MAX_RPL(MAX_RPL)) u_dec (
      .verb(cmd_verb), .nargs(cmd_nargs), .args(cmd_args),
      .kind(d_kind), .n_tx(d_ntx), .tx_bytes(d_tx), .n_rx(d_nrx)
   );

   st_e              st;
   kind_e            kind_q;
   logic [NTX*8-1:0] tx_q;
   logic [CW-1:0]    ntx_q, txi_q;
   logic [RW-1:0]    nrx_q;
   logic [7:0]       code_q;
   logic [RW-1:0]    rx_cnt;
   logic             cmd_fire, rx_wr;
   logic [NTX*8-1:0] tx_shift;

   assign cmd_ready = (st == ST_IDLE);
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign rx_wr     = (st == ST_RECV) && lnk_done;

   dcs_rx_buf #(.MAX_RPL(MAX_RPL)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(cmd_fire), .wr_en(rx_wr),
      .wr_byte(lnk_rdata), .data(rsp_data), .count(rx_cnt)
   );

   assign tx_shift  = tx_q >> {txi_q, 3'b000};
   assign lnk_req   = (st == ST_SEND) || (st == ST_RECV) || (st == ST_SYS);
   assign lnk_wdata = (st == ST_SEND) ? tx_shift[7:0] : 8'h00;
   always_comb begin
      case (st)
         ST_RECV: lnk_op = LOP_READ;
         ST_SYS:  lnk_op = (kind_q == KIND_ENTER) ? LOP_ENTER : LOP_EXIT;
         default: lnk_op = LOP_WRITE;
      endcase
   end

   assign rsp_valid = (st == ST_RESP);
   assign rsp_code  = code_q;
   assign rsp_len   = rx_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         kind_q <= KIND_NAK;
         tx_q   <= '0;
         ntx_q  <= '0;
         txi_q  <= '0;
         nrx_q  <= '0;
         code_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (cmd_fire) begin
               kind_q <= d_kind;
               tx_q   <= d_tx;
               ntx_q  <= d_ntx;
               nrx_q  <= d_nrx;
               txi_q  <= '0;
               code_q <= (d_kind == KIND_NAK) ? CODE_NAK : cmd_verb;
               case (d_kind)
                  KIND_NAK:   st <= ST_RESP;
                  KIND_ENTER,
                  KIND_EXIT:  st <= ST_SYS;
                  default:    st <= (d_ntx != '0) ? ST_SEND :
                                    (d_nrx != '0) ? ST_RECV : ST_RESP;
               endcase
            end
            ST_SEND: if (lnk_done) begin
               txi_q <= txi_q + CW'(1);
               if (txi_q == ntx_q - CW'(1))
                  st <= (nrx_q != '0) ? ST_RECV : ST_RESP;
            end
            ST_RECV: if (lnk_done && rx_cnt == nrx_q - RW'(1)) st <= ST_RESP;
            ST_SYS:  if (lnk_done) st <= ST_RESP;
            ST_RESP: if (rsp_ready) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R8: a refused verb goes straight to a NAK reply with no link traffic
   a_r8_nak_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_fire && d_kind == KIND_NAK |=> !lnk_req && rsp_valid &&
      rsp_code == CODE_NAK && rsp_len == '0);

   // R10: no second command is taken once one is accepted
   a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_fire |=> !cmd_ready);

   // R10: a reply that is not taken holds its contents
   a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) &&
      $stable(rsp_len) && $stable(rsp_data));

   // R11: a pending link request keeps its operation and byte
   a_r11_lnk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_req && !lnk_done |=> lnk_req && $stable(lnk_op) && $stable(lnk_wdata));

   // R2: the generic read verb always returns exactly one byte
   a_r2_gen_read_len: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_code == VERB_GEN_READ |-> rsp_len == RW'(1));
endmodule

// File: tb/dcs_seq_tb.sv
`timescale 1ns/1ps
module dcs_seq_tb;
   import dcs_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [7:0]  cmd_verb = '0;
   logic [1:0]  cmd_nargs = '0;
   logic [15:0] cmd_args = '0;
   logic        lnk_req;
   logic [1:0]  lnk_op;
   logic [7:0]  lnk_wdata;
   logic        lnk_done = 1'b0;
   logic [7:0]  lnk_rdata = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [7:0]  rsp_code;
   logic [1:0]  rsp_len;
   logic [15:0] rsp_data;

   always #2.5 clk = ~clk;

   dcs_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_verb(cmd_verb), .cmd_nargs(cmd_nargs), .cmd_args(cmd_args),
      .lnk_req(lnk_req), .lnk_op(lnk_op), .lnk_wdata(lnk_wdata),
      .lnk_done(lnk_done), .lnk_rdata(lnk_rdata), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_len(rsp_len),
      .rsp_data(rsp_data)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 0;
   logic [7:0] cur_verb = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s verb=%h actual=%h expected=%h", req, what, cur_verb, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // transceiver model: completes each operation on its second cycle
   logic [1:0] log_op [16];
   logic [7:0] log_wd [16];
   logic [7:0] log_rd [16];
   int         log_n = 0;
   initial begin
      int         lat = 0;
      logic [7:0] rd_next = 8'h31;
      logic [1:0] held_op = '0;
      logic [7:0] held_wd = '0;
      forever begin
         @(negedge clk);
         lnk_done = 1'b0;
         if (rst_n && lnk_req) begin
            lat++;
            if (lat == 1) begin
               held_op = lnk_op;
               held_wd = lnk_wdata;
            end else begin
               chk(lnk_op == held_op && lnk_wdata == held_wd, "R11", "link hold",
                   {22'd0, lnk_op, lnk_wdata}, {22'd0, held_op, held_wd});
               lat       = 0;
               lnk_done  = 1'b1;
               lnk_rdata = rd_next;
               if (log_n < 16) begin
                  log_op[log_n] = lnk_op;
                  log_wd[log_n] = lnk_wdata;
                  log_rd[log_n] = rd_next;
               end
               log_n++;
               rd_next = rd_next + 8'h27;
            end
         end else lat = 0;
      end
   end

   function automatic string req_of(input logic [7:0] v);
      case (v)
         8'h00: return "R2";
         8'h01: return "R3";
         8'h20, 8'h21: return "R9";
         8'h80: return "R4";
         8'h81: return "R5";
         8'h82, 8'h84, 8'h86, 8'h87, 8'h89: return "R6";
         8'h83, 8'h8B: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic run_cmd(input logic [7:0] v, input int na,
                          input logic [7:0] a0, input logic [7:0] a1);
      logic [1:0]  e_op [8];
      logic [7:0]  e_wd [8];
      int          e_n = 0;
      int          e_rx = 0;
      logic [7:0]  e_code = v;
      logic [15:0] e_data = '0;
      logic [7:0]  c;
      logic [1:0]  l;
      logic [15:0] d;
      bit          seq_ok;
      int          rj = 0;
      int          wd = 0;
      string       rq = req_of(v);
      cur_verb = v;
      case (v)
         8'h00, 8'h01: begin
            if (na > 0) begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = a0; e_n++; end
            if (na > 1) begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = a1; e_n++; end
            e_rx = (v == 8'h00) ? 1 : 0;
         end
         8'h20: begin e_op[e_n] = LOP_ENTER; e_wd[e_n] = 8'h00; e_n++; end
         8'h21: begin e_op[e_n] = LOP_EXIT;  e_wd[e_n] = 8'h00; e_n++; end
         8'h80: begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = 8'h14; e_n++; e_rx = 1; end
         8'h81: begin
            e_op[e_n] = LOP_WRITE; e_wd[e_n] = 8'h1D; e_n++;
            e_op[e_n] = LOP_WRITE; e_wd[e_n] = a0;    e_n++;
            e_rx = 1;
         end
         8'h82: begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = 8'h24; e_n++; e_rx = 1; end
         8'h84: begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = 8'h34; e_n++; e_rx = 1; end
         8'h86: begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = 8'h44; e_n++; e_rx = 1; end
         8'h87: begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = 8'h4C; e_n++; e_rx = 1; end
         8'h89: begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = 8'h5C; e_n++; e_rx = 1; end
         8'h83: begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = 8'h28; e_n++; e_rx = 2; end
         8'h8B: begin e_op[e_n] = LOP_WRITE; e_wd[e_n] = 8'h68; e_n++; e_rx = 2; end
         default: e_code = 8'h7E;
      endcase
      for (int k = 0; k < e_rx; k++) begin
         e_op[e_n] = LOP_READ; e_wd[e_n] = 8'h00; e_n++;
      end

      log_n = 0;
      @(negedge clk);
      cmd_verb  = v;
      cmd_nargs = 2'(na);
      cmd_args  = {a1, a0};
      cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, "R10", "busy after accept", {31'd0, cmd_ready}, 32'd0);

      while (!rsp_valid && wd < 100) begin @(negedge clk); wd++; end
      c = rsp_code; l = rsp_len; d = rsp_data;
      @(negedge clk);
      chk(rsp_valid && rsp_code == c && rsp_len == l && rsp_data == d && !cmd_ready,
          "R10", "reply hold", {15'd0, rsp_valid, rsp_data}, {15'd1, d});

      seq_ok = (log_n == e_n);
      for (int k = 0; k < e_n && k < 16; k++) begin
         if (log_op[k] != e_op[k]) seq_ok = 0;
         if (e_op[k] == LOP_WRITE && log_wd[k] != e_wd[k]) seq_ok = 0;
         if (e_op[k] == LOP_READ && log_op[k] == LOP_READ) begin
            e_data[rj*8 +: 8] = log_rd[k];
            rj++;
         end
      end
      chk(seq_ok, rq, "link sequence", 32'(log_n), 32'(e_n));
      chk(c == e_code, rq, "reply code", {24'd0, c}, {24'd0, e_code});
      chk(32'(l) == 32'(e_rx), rq, "reply length", {30'd0, l}, 32'(e_rx));
      chk(d == e_data, rq, "reply data", {16'd0, d}, {16'd0, e_data});

      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid && cmd_ready, "R10", "idle after handoff",
          {30'd0, rsp_valid, cmd_ready}, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b1 && rsp_valid == 1'b0 && lnk_req == 1'b0, "R1", "reset state",
          {29'd0, cmd_ready, rsp_valid, lnk_req}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1 && rsp_valid == 1'b0 && lnk_req == 1'b0, "R1", "after release",
          {29'd0, cmd_ready, rsp_valid, lnk_req}, 32'd4);
      // generic verbs with every argument count
      for (int na = 0; na < 3; na++) begin
         run_cmd(8'h00, na, 8'hC3, 8'h5E);
         run_cmd(8'h01, na, 8'hA7, 8'h19);
      end
      // full verb sweep with two arguments each
      for (int v = 0; v < 256; v++) begin
         run_cmd(8'(v), 2, 8'(v) ^ 8'h5A, ~8'(v));
      end
      // back-to-back two-byte replies keep arrival order
      run_cmd(8'h8B, 0, 8'h00, 8'h00);
      run_cmd(8'h83, 1, 8'hFF, 8'h00);
      finish_run();
   end
endmodule